// File: doc/BRIEF.md
# Page-Aligned Program Chunk Splitter

This block accepts one byte-write request, given as a start address and a byte count, and turns it into a sequence of program chunks for a downstream flash program engine. No chunk crosses a 256-byte page boundary. A request that starts in the middle of a page first gets a short leading chunk that runs up to the next page boundary. Whole aligned pages follow, and a final chunk carries any remainder shorter than a page. A request that fits inside one page goes out as a single chunk, unchanged.

Each chunk is offered with a valid/ready handshake. It carries the flash address, the length and the offset into the caller's source buffer. After the engine accepts a chunk, the splitter waits for a completion strobe from the engine before it offers the next chunk. When the last chunk completes, it raises a one-cycle done pulse. A zero-length request produces only the done pulse.

Top module: `page_write_splitter`

## Requirements
- R1: Every offered chunk satisfies (chunk_addr mod 256) + chunk_len <= 256, and chunk_len is never zero.
- R2: If start address and start address + length fall in the same 256-byte page (page number = address / 256), exactly one chunk is offered, with chunk_addr = req_addr and chunk_len = req_len.
- R3: Otherwise the first chunk starts at req_addr and has length 256 - (req_addr mod 256).
- R4: After the first chunk, while at least 256 bytes remain, each chunk is 256 bytes long and starts on an address whose low 8 bits are zero.
- R5: A remainder of 1 to 255 bytes is offered as the final chunk, page-aligned.
- R6: chunk_index equals the sum of the lengths of all earlier chunks of the same request, and chunk_addr = req_addr + chunk_index.
- R7: A start with req_len = 0 offers no chunk, and req_done is high in the cycle after the start.
- R8: chunk_valid and the chunk fields hold steady until chunk_ready is seen. chunk_valid drops in the cycle after acceptance. The next chunk is offered only in the cycle after chunk_cmplt is seen high.
- R9: req_done is a single-cycle pulse in the cycle after chunk_cmplt for the final chunk, and it is never high together with chunk_valid.
- R10: req_start while a request is in progress is ignored; the running request's chunks are unchanged and no extra done pulse appears.
- R11: After reset, chunk_valid and req_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start strobe; sampled only when idle |
| req_addr | input | ADDR_W (24) | Start byte address of the write |
| req_len | input | LEN_W (16) | Total byte count |
| chunk_valid | output | 1 | A chunk is being offered |
| chunk_ready | input | 1 | Engine accepts the offered chunk |
| chunk_addr | output | ADDR_W (24) | Flash address of the chunk |
| chunk_len | output | PAGE_SHIFT+1 (9) | Chunk length in bytes, 1 to 256 |
| chunk_index | output | LEN_W (16) | Offset of the chunk in the source buffer |
| chunk_cmplt | input | 1 | Engine finished programming the accepted chunk |
| req_done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The directed cases cover the layouts where a splitter most easily goes wrong. One case starts a few bytes before a boundary, which would expose a first length computed as the full page, or one that crosses into the next page. Others cover requests that end exactly on a boundary or that are a single aligned page, where an off-by-one in the end-page test would add an empty or a duplicate chunk. A zero-length request would hang or emit a zero-byte chunk in a faulty design. Stalling the ready and completion strobes, and pulsing start during a transfer, would show a chunk offered early, fields that drift while waiting, or a request restarted midway.

// File: rtl/pws_pkg.sv
// Shared types for the page write splitter.
package pws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } pws_state_e;
endpackage

// File: rtl/pws_chunk_sizer.sv
// Chunk sizer: picks the length of the next chunk as the smaller of the
// bytes still to send and the room left in the current page.
// Assumes remaining is nonzero whenever the result is used.
module pws_chunk_sizer #(
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8,
    localparam int CLEN_W    = PAGE_SHIFT + 1
) (
    input  logic [PAGE_SHIFT-1:0] page_off,
    input  logic [LEN_W-1:0]      remaining,
    output logic [CLEN_W-1:0]     chunk_len
);
    localparam logic [CLEN_W-1:0] PAGE_BYTES = CLEN_W'(1) << PAGE_SHIFT;

    logic [CLEN_W-1:0] room;

    // Bytes from the cursor to the end of its page.
    assign room = PAGE_BYTES - {1'b0, page_off};

    // Clip the page room to what is left of the request.
    always_comb begin
        if (remaining < LEN_W'(room))
            chunk_len = remaining[CLEN_W-1:0];
        else
            chunk_len = room;
    end
endmodule

// File: rtl/pws_cursor.sv
// Cursor: holds the current flash address, the bytes still to send and the
// source buffer offset. Loads on a request start and advances by one chunk
// length on each completion. Assumes load and step are never both high.
module pws_cursor #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8,
    localparam int CLEN_W    = PAGE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    input  logic [CLEN_W-1:0] step_len,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  remaining,
    output logic [LEN_W-1:0]  buf_index
);
    // Load on start, advance by one chunk when a chunk completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            buf_index <= '0;
        end else if (load) begin
            cur_addr  <= load_addr;
            remaining <= load_len;
            buf_index <= '0;
        end else if (step) begin
            cur_addr  <= cur_addr + ADDR_W'(step_len);
            remaining <= remaining - LEN_W'(step_len);
            buf_index <= buf_index + LEN_W'(step_len);
        end
    end
endmodule

// File: rtl/pws_sequencer.sv
// Sequencer: idle / offer chunk / wait for completion. Offers one chunk at a
// time and pulses done after the last completion, or straight away for an
// empty request. Assumes chunk_cmplt arrives only after an accepted chunk.
module pws_sequencer
    import pws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic len_zero,
    input  logic last_chunk,
    input  logic chunk_ready,
    input  logic chunk_cmplt,
    output logic load,
    output logic step,
    output logic chunk_valid,
    output logic done
);
    pws_state_e state, state_nx;
    logic       done_nx;

    // Next-state and control strobes.
    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (len_zero) done_nx  = 1'b1;
                    else          state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (chunk_ready) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (chunk_cmplt) begin
                    step = 1'b1;
                    if (last_chunk) begin
                        state_nx = ST_IDLE;
                        done_nx  = 1'b1;
                    end else begin
                        state_nx = ST_ISSUE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= done_nx;
        end
    end

    assign chunk_valid = (state == ST_ISSUE);

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && len_zero) |=> (done && !chunk_valid)); // R7
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !chunk_ready) |=> chunk_valid); // R8
    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && chunk_ready) |=> !chunk_valid); // R8
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chunk_valid); // R9
endmodule

// File: rtl/page_write_splitter.sv
// Page write splitter top: breaks a byte write request into chunks that never
// cross a page, offering each over valid/ready and waiting for the engine's
// completion strobe before the next. Assumes the engine raises chunk_cmplt
// once per accepted chunk.
module page_write_splitter #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8,
    localparam int CLEN_W    = PAGE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              chunk_valid,
    input  logic              chunk_ready,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [CLEN_W-1:0] chunk_len,
    output logic [LEN_W-1:0]  chunk_index,
    input  logic              chunk_cmplt,
    output logic              req_done
);
    localparam logic [CLEN_W:0] PAGE_BYTES = (CLEN_W+1)'(1) << PAGE_SHIFT;

    logic             load, step, last_chunk, len_zero;
    logic [LEN_W-1:0] remaining;

    pws_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (step),
        .step_len  (chunk_len),
        .cur_addr  (chunk_addr),
        .remaining (remaining),
        .buf_index (chunk_index)
    );

    pws_chunk_sizer #(.LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_sizer (
        .page_off  (chunk_addr[PAGE_SHIFT-1:0]),
        .remaining (remaining),
        .chunk_len (chunk_len)
    );

    // Request end detection for the sequencer.
    assign len_zero   = (req_len == '0);
    assign last_chunk = (remaining == LEN_W'(chunk_len));

    pws_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_start),
        .len_zero    (len_zero),
        .last_chunk  (last_chunk),
        .chunk_ready (chunk_ready),
        .chunk_cmplt (chunk_cmplt),
        .load        (load),
        .step        (step),
        .chunk_valid (chunk_valid),
        .done        (req_done)
    );

    AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (({1'b0, {1'b0, chunk_addr[PAGE_SHIFT-1:0]}} + {1'b0, chunk_len}) <= PAGE_BYTES)
                        && (chunk_len != '0)); // R1
    AST_FULL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && {1'b0, chunk_len} == PAGE_BYTES) |-> (chunk_addr[PAGE_SHIFT-1:0] == '0)); // R4
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !chunk_ready) |=> ($stable(chunk_addr) && $stable(chunk_len) && $stable(chunk_index))); // R8
endmodule

// File: tb/page_write_splitter_test.sv
`timescale 1ns/1ps
module page_write_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        chunk_valid, chunk_ready = 1'b0, chunk_cmplt = 1'b0, req_done;
    logic [23:0] chunk_addr;
    logic [8:0]  chunk_len;
    logic [15:0] chunk_index;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    page_write_splitter uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_addr(chunk_addr), .chunk_len(chunk_len), .chunk_index(chunk_index),
        .chunk_cmplt(chunk_cmplt), .req_done(req_done)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One request, checked chunk by chunk against a model built from the rules.
    task automatic run_req(input logic [23:0] a, input int l, input int rlag,
                           input int clag, input bit poke);
        int ea[0:63];
        int el[0:63];
        int n = 0;
        int rem;
        int cur;
        int acc = 0;
        int w;
        string tag;
        if (l != 0) begin
            if ((a >> 8) == ((int'(a) + l) >> 8)) begin
                ea[0] = int'(a); el[0] = l; n = 1;
            end else begin
                ea[0] = int'(a); el[0] = 256 - (int'(a) % 256); n = 1;
                cur = int'(a) + el[0]; rem = l - el[0];
                while (rem >= 256) begin
                    ea[n] = cur; el[n] = 256; n++; cur += 256; rem -= 256;
                end
                if (rem > 0) begin
                    ea[n] = cur; el[n] = rem; n++;
                end
            end
        end
        @(negedge clk);
        req_start = 1'b1; req_addr = a; req_len = 16'(l);
        @(negedge clk);
        req_start = 1'b0; req_addr = 24'hFFFFFF; req_len = 16'hFFFF;
        if (n == 0) begin
            chk(req_done == 1'b1, "R7", "done after empty request", req_done, 1);
            chk(chunk_valid == 1'b0, "R7", "no chunk for empty request", chunk_valid, 0);
            @(negedge clk);
            chk(chunk_valid == 1'b0 && req_done == 1'b0, "R7", "quiet after empty request",
                {chunk_valid, req_done}, 0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            w = 0;
            while (!chunk_valid && w < 50) begin @(negedge clk); w++; end
            if (n == 1) tag = "R2";
            else if (k == 0) tag = "R3";
            else if (el[k] < 256) tag = "R5";
            else tag = "R4";
            chk(chunk_valid == 1'b1, tag, "chunk offered", chunk_valid, 1);
            chk(int'(chunk_addr) == (ea[k] & 24'hFFFFFF), tag, "chunk address", chunk_addr, ea[k]);
            chk(int'(chunk_len) == el[k], tag, "chunk length", chunk_len, el[k]);
            chk(int'(chunk_index) == acc, "R6", "buffer index", chunk_index, acc);
            chk((int'(chunk_addr[7:0]) + int'(chunk_len)) <= 256, "R1", "page bound",
                int'(chunk_addr[7:0]) + int'(chunk_len), 256);
            for (int d = 0; d < rlag; d++) begin
                @(negedge clk);
                chk(chunk_valid == 1'b1 && int'(chunk_len) == el[k], "R8", "held while not ready",
                    chunk_len, el[k]);
            end
            chunk_ready = 1'b1;
            @(negedge clk);
            chunk_ready = 1'b0;
            chk(chunk_valid == 1'b0, "R8", "valid drops after accept", chunk_valid, 0);
            if (poke) begin
                req_start = 1'b1; req_addr = 24'h000003; req_len = 16'd5;
                @(negedge clk);
                req_start = 1'b0;
                chk(chunk_valid == 1'b0 && req_done == 1'b0, "R10", "start while busy ignored",
                    {chunk_valid, req_done}, 0);
            end
            for (int d = 0; d < clag; d++) begin
                @(negedge clk);
                chk(chunk_valid == 1'b0, "R8", "no chunk before completion", chunk_valid, 0);
            end
            chunk_cmplt = 1'b1;
            @(negedge clk);
            chunk_cmplt = 1'b0;
            acc += el[k];
            if (k == n - 1) begin
                chk(req_done == 1'b1, "R9", "done after last completion", req_done, 1);
                @(negedge clk);
                chk(req_done == 1'b0 && chunk_valid == 1'b0, "R9", "done is one pulse",
                    {chunk_valid, req_done}, 0);
            end else begin
                chk(chunk_valid == 1'b1 && req_done == 1'b0, "R8", "next chunk after completion",
                    {chunk_valid, req_done}, 2);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(chunk_valid == 1'b0 && req_done == 1'b0, "R11", "reset state", {chunk_valid, req_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chunk_valid == 1'b0 && req_done == 1'b0, "R11", "idle after reset", {chunk_valid, req_done}, 0);
        run_req(24'h000010, 32, 0, 0, 1'b0);   // inside one page
        run_req(24'h000100, 256, 2, 1, 1'b0);  // one aligned page, end on boundary
        run_req(24'h0000F0, 600, 1, 3, 1'b0);  // lead, two full, tail
        run_req(24'h000200, 512, 0, 2, 1'b1);  // aligned, two full pages, busy pokes
        run_req(24'h0001F0, 272, 3, 0, 1'b0);  // lead then one full page, no tail
        run_req(24'h0003FF, 2, 0, 0, 1'b0);    // one byte before a boundary
        run_req(24'h000040, 0, 0, 0, 1'b0);    // empty request
        run_req(24'hFFFF80, 100, 1, 1, 1'b0);  // single page near the top of the space
        run_req(24'h012345, 1000, 0, 1, 1'b1); // long unaligned request
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule